// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block is a position and event counter for a motor or knob encoder. It also works as a plain timebase. Four counting functions can be selected at run time:

- **Clock counting.** The counter advances on a divided copy of the core clock.
- **A-edge counting.** The counter follows both edges of channel A only.
- **B-edge counting.** The counter follows both edges of channel B only.
- **Both-edge counting.** The counter follows every edge of both channels.

In the quadrature functions the level of the opposite channel sets the direction, so a shaft turning either way moves the count up or down.

The count always stays between zero and a programmable ceiling. Stepping up past the ceiling, or down past zero, wraps the count and emits a one-cycle update pulse. Software can also force that pulse with a strobe. An update pulse does three things:

- It moves a buffered ceiling into use.
- It moves the buffered prescaler value into use.
- It restarts the prescaler, when the pulse comes from the strobe.

The ceiling can instead be written straight into use when buffering is off. A status output tells whether the last step went downward.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the direction output is 0 and no update pulse is present. While the enable input is low, the count does not move in any function.
- R2: In clock counting (mode code 0), an active prescaler value P gives one count every P+1 clock cycles.
- R3: In A-edge counting (mode code 1), each edge of A steps the count, and edges of B alone do nothing. The step is up when A's new level differs from B's level, and down otherwise. The order 00,10,11,01 of the pair {A,B} counts up.
- R4: In B-edge counting (mode code 2), each edge of B steps the count, and edges of A alone do nothing. The step is up when B's new level equals A's level, and down otherwise.
- R5: In both-edge counting (mode code 3), every single-channel edge steps the count. One full Gray cycle moves the count by four, and the reverse cycle moves it back by four.
- R6: A sample in which A and B change together leaves the count unchanged.
- R7: Counting up from a count at or above the ceiling gives 0, and the update pulse shows in the same cycle as the 0.
- R8: Counting down from 0 gives the ceiling value, and the update pulse shows in the same cycle as that value.
- R9: The direction output is 1 after a downward step and 0 after an upward step. It is 0 whenever clock counting is selected.
- R10: With ceiling buffering off, a ceiling write is in use from the next cycle.
- R11: With ceiling buffering on, a ceiling write waits until the next update pulse.
- R12: The force strobe gives an update pulse one cycle later. It puts the buffered prescaler and ceiling into use and restarts the prescaler, and it does not change the count. Prescaler writes always wait for an update pulse.
- R13: In clock counting, activity on A and B has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Counting enable |
| cnt_mode | input | 2 | Function: 0 clock, 1 A-edge, 2 B-edge, 3 both-edge |
| ceil_din | input | CNT_W | Ceiling write data |
| ceil_wr | input | 1 | Ceiling write strobe |
| ceil_buffered | input | 1 | 1: ceiling writes wait for an update pulse |
| div_din | input | PSC_W | Prescaler write data (divide by value+1) |
| div_wr | input | 1 | Prescaler write strobe |
| force_upd | input | 1 | Software update strobe |
| quad_a | input | 1 | Encoder channel A (asynchronous) |
| quad_b | input | 1 | Encoder channel B (asynchronous) |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | 1 when the last step was downward |
| upd_pulse | output | 1 | One-cycle update event |

## Verification
The encoder functions are driven with three kinds of input:

- **Forward and reverse Gray sequences.** These separate the up and down decisions of each mode.
- **Mixed sequences with edges on the channel a mode ignores.** These show that A-edge and B-edge counting are not swapped.
- **A step where both channels change at once.** This is the illegal transition.

Clock counting is measured as count differences over fixed windows, at two prescaler settings and while the encoder pins toggle.

Wrap behaviour is checked by counting update pulses over windows of a known period. Small ceilings are written with buffering both on and off, which separates immediate loading from loading on the update event.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    typedef enum logic [1:0] {
        QM_CLOCK = 2'd0,
        QM_X2A   = 2'd1,
        QM_X2B   = 2'd2,
        QM_X4    = 2'd3
    } qmode_e;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    logic [N-1:0] s1_q, s2_q, s3_q;
    logic [N-1:0] s1_d, s2_d, s3_d;

    always_comb begin
        s1_d = raw;
        s2_d = s1_q;
        s3_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign cur  = s2_q;
    assign prev = s3_q;
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  qmode_e mode,
    input  logic   a_cur,
    input  logic   b_cur,
    input  logic   a_prev,
    input  logic   b_prev,
    output logic   step_up,
    output logic   step_dn
);
    logic a_only, b_only;

    always_comb begin
        a_only  = (a_cur ^ a_prev) & ~(b_cur ^ b_prev);
        b_only  = (b_cur ^ b_prev) & ~(a_cur ^ a_prev);
        step_up = 1'b0;
        step_dn = 1'b0;
        case (mode)
            QM_X2A: begin
                if (a_only) begin
                    step_up = (a_cur != b_cur);
                    step_dn = (a_cur == b_cur);
                end
            end
            QM_X2B: begin
                if (b_only) begin
                    step_up = (b_cur == a_cur);
                    step_dn = (b_cur != a_cur);
                end
            end
            QM_X4: begin
                if (a_only) begin
                    step_up = (a_cur != b_cur);
                    step_dn = (a_cur == b_cur);
                end else if (b_only) begin
                    step_up = (b_cur == a_cur);
                    step_dn = (b_cur != a_cur);
                end
            end
            default: begin
                step_up = 1'b0;
                step_dn = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qenc_prescale.sv
module qenc_prescale #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] limit,
    output logic             tick
);
    logic [PSC_W-1:0] cnt_q, cnt_d;

    always_comb begin
        tick  = run && (cnt_q >= limit);
        cnt_d = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (run)
            cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int              CNT_W    = 16,
    parameter int              PSC_W    = 16,
    parameter logic [CNT_W-1:0] CEIL_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [1:0]       cnt_mode,
    input  logic [CNT_W-1:0] ceil_din,
    input  logic             ceil_wr,
    input  logic             ceil_buffered,
    input  logic [PSC_W-1:0] div_din,
    input  logic             div_wr,
    input  logic             force_upd,
    input  logic             quad_a,
    input  logic             quad_b,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             upd_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ceil;
        logic [CNT_W-1:0] ceil_sh;
        logic [PSC_W-1:0] psc;
        logic [PSC_W-1:0] psc_sh;
        logic             down;
        logic             upd;
    } state_t;

    state_t q, d;
    qmode_e mode;
    logic [1:0] pins_cur, pins_prev;
    logic q_up, q_dn, tick, up_req, dn_req, wrap, upd_now;

    assign mode = qmode_e'(cnt_mode);

    qenc_sync #(.N(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({quad_a, quad_b}),
        .cur  (pins_cur),
        .prev (pins_prev)
    );

    qenc_decode u_dec (
        .mode   (mode),
        .a_cur  (pins_cur[1]),
        .b_cur  (pins_cur[0]),
        .a_prev (pins_prev[1]),
        .b_prev (pins_prev[0]),
        .step_up(q_up),
        .step_dn(q_dn)
    );

    qenc_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cnt_en && (mode == QM_CLOCK)),
        .restart(force_upd),
        .limit  (q.psc),
        .tick   (tick)
    );

    always_comb begin
        d      = q;
        wrap   = 1'b0;
        up_req = (mode == QM_CLOCK) ? tick : (cnt_en && q_up);
        dn_req = (mode != QM_CLOCK) && cnt_en && q_dn;

        if (up_req) begin
            d.down = 1'b0;
            if (q.cnt >= q.ceil) begin
                d.cnt = '0;
                wrap  = 1'b1;
            end else begin
                d.cnt = q.cnt + ONE;
            end
        end else if (dn_req) begin
            d.down = 1'b1;
            if (q.cnt == '0) begin
                d.cnt = q.ceil;
                wrap  = 1'b1;
            end else begin
                d.cnt = q.cnt - ONE;
            end
        end
        if (mode == QM_CLOCK) d.down = 1'b0;

        if (ceil_wr) begin
            d.ceil_sh = ceil_din;
            if (!ceil_buffered) d.ceil = ceil_din;
        end
        if (div_wr) d.psc_sh = div_din;

        upd_now = wrap || force_upd;
        if (upd_now) begin
            d.psc = d.psc_sh;
            if (ceil_buffered) d.ceil = d.ceil_sh;
        end
        d.upd = upd_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt     <= '0;
            q.ceil    <= CEIL_RST;
            q.ceil_sh <= CEIL_RST;
            q.psc     <= '0;
            q.psc_sh  <= '0;
            q.down    <= 1'b0;
            q.upd     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign count     = q.cnt;
    assign dir_down  = q.down;
    assign upd_pulse = q.upd;

    assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> count == $past(count));

    assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |-> (count == $past(count)) || (count == $past(count) + ONE)
                       || (count == $past(count) - ONE));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_up, q_dn}));

    assert_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !$past(force_upd) && !dir_down) |-> count == '0);

    assert_wrap_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !$past(force_upd) && dir_down) |-> count == $past(q.ceil));

    assert_clock_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd0) |=> !dir_down);

    assert_force_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> upd_pulse);
endmodule

// File: tb/qenc_counter_bench.sv
`timescale 1ns/1ps
module qenc_counter_bench;
    localparam int CNT_W = 16;
    localparam int PSC_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_en = 1'b0;
    logic [1:0]       cnt_mode = 2'd0;
    logic [CNT_W-1:0] ceil_din = '0;
    logic             ceil_wr = 1'b0;
    logic             ceil_buffered = 1'b0;
    logic [PSC_W-1:0] div_din = '0;
    logic             div_wr = 1'b0;
    logic             force_upd = 1'b0;
    logic             quad_a = 1'b0;
    logic             quad_b = 1'b0;
    logic [CNT_W-1:0] count;
    logic             dir_down;
    logic             upd_pulse;

    int checks = 0;
    int fails = 0;
    int upd_seen = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    qenc_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_qenc_counter (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_mode(cnt_mode),
        .ceil_din(ceil_din), .ceil_wr(ceil_wr), .ceil_buffered(ceil_buffered),
        .div_din(div_din), .div_wr(div_wr), .force_upd(force_upd),
        .quad_a(quad_a), .quad_b(quad_b), .count(count),
        .dir_down(dir_down), .upd_pulse(upd_pulse)
    );

    always @(negedge clk) if (rst_n && upd_pulse) upd_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b0; cnt_mode = 2'd0; ceil_wr = 1'b0;
        ceil_buffered = 1'b0; div_wr = 1'b0; force_upd = 1'b0;
        quad_a = 1'b0; quad_b = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_ceil(input int v);
        ceil_din = CNT_W'(v); ceil_wr = 1'b1;
        @(negedge clk);
        ceil_wr = 1'b0;
    endtask

    task automatic wr_div(input int v);
        div_din = PSC_W'(v); div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic pulse_force();
        force_upd = 1'b1;
        @(negedge clk);
        force_upd = 1'b0;
    endtask

    task automatic qset(input logic a, input logic b);
        quad_a = a; quad_b = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset count", count, 0);
        chk("R1 reset dir", dir_down, 0);
        chk("R1 reset pulse", upd_pulse, 0);
    endtask

    task automatic t_clock();
        int c0;
        do_reset();
        cnt_mode = 2'd0; cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        c0 = count; repeat (5) @(negedge clk);
        chk("R1 clock rate psc0", count - c0, 5);
        c0 = count;
        for (int i = 0; i < 10; i++) begin
            quad_a = ~quad_a; quad_b = i[1];
            @(negedge clk);
        end
        chk("R13 pins ignored", count - c0, 10);
        chk("R9 clock dir", dir_down, 0);
        wr_div(2);
        c0 = count; repeat (8) @(negedge clk);
        chk("R12 div waits for update", count - c0, 8);
        pulse_force();
        repeat (2) @(negedge clk);
        c0 = count; repeat (12) @(negedge clk);
        chk("R2 divide by 3", count - c0, 4);
        cnt_en = 1'b0;
        @(negedge clk);
        c0 = count; repeat (10) @(negedge clk);
        chk("R1 hold when disabled", count - c0, 0);
        c0 = count; pulse_force();
        @(negedge clk);
        chk("R12 force keeps count", count, c0);
    endtask

    task automatic t_force_pulse();
        do_reset();
        force_upd = 1'b1;
        @(negedge clk);
        force_upd = 1'b0;
        chk("R12 force pulse", upd_pulse, 1);
        @(negedge clk);
        chk("R12 pulse one cycle", upd_pulse, 0);
    endtask

    task automatic t_x2a();
        do_reset();
        cnt_mode = 2'd1; cnt_en = 1'b1; wr_ceil(1000);
        qset(1, 0); qset(1, 1); qset(0, 1); qset(0, 0);
        chk("R3 x2A forward", count, 2);
        chk("R9 up dir", dir_down, 0);
        qset(0, 1); qset(1, 1);
        chk("R3 x2A reverse", count, 1);
        chk("R9 down dir", dir_down, 1);
    endtask

    task automatic t_x2b();
        do_reset();
        cnt_mode = 2'd2; cnt_en = 1'b1; wr_ceil(1000);
        qset(1, 0); qset(1, 1); qset(0, 1); qset(0, 0);
        chk("R4 x2B forward", count, 2);
        qset(0, 1);
        chk("R4 x2B reverse", count, 1);
    endtask

    task automatic t_x4();
        do_reset();
        cnt_mode = 2'd3; cnt_en = 1'b1; wr_ceil(1000);
        qset(1, 0); qset(1, 1); qset(0, 1); qset(0, 0);
        chk("R5 x4 forward", count, 4);
        qset(0, 1); qset(1, 1); qset(1, 0); qset(0, 0);
        chk("R5 x4 reverse", count, 0);
        qset(1, 1);
        chk("R6 illegal jump", count, 0);
        qset(0, 0);
        chk("R6 illegal jump back", count, 0);
        cnt_en = 1'b0;
        qset(1, 0); qset(1, 1);
        chk("R1 quad hold disabled", count, 0);
    endtask

    task automatic t_wrap_up();
        int prev, p0;
        do_reset();
        wr_ceil(5);
        cnt_mode = 2'd0; cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        p0 = upd_seen;
        for (int i = 0; i < 12; i++) begin
            prev = count;
            @(negedge clk);
            if (upd_pulse) begin
                chk("R7 before wrap", prev, 5);
                chk("R7 after wrap", count, 0);
            end
        end
        chk("R7 pulses per window", upd_seen - p0, 2);
    endtask

    task automatic t_wrap_down();
        int p0;
        do_reset();
        cnt_mode = 2'd3; cnt_en = 1'b1; wr_ceil(7);
        p0 = upd_seen;
        qset(0, 1);
        chk("R8 down wrap value", count, 7);
        chk("R8 down wrap pulse", upd_seen - p0, 1);
        chk("R9 down wrap dir", dir_down, 1);
    endtask

    task automatic t_preload();
        int p0;
        do_reset();
        cnt_mode = 2'd0; ceil_buffered = 1'b1;
        wr_ceil(3);
        cnt_en = 1'b1;
        repeat (12) @(negedge clk);
        chk("R11 buffered ceiling not yet used", int'(count > 3), 1);
        pulse_force();
        repeat (3) @(negedge clk);
        p0 = upd_seen;
        repeat (8) @(negedge clk);
        chk("R11 buffered ceiling after update", upd_seen - p0, 2);
    endtask

    task automatic t_immediate();
        int p0;
        do_reset();
        cnt_mode = 2'd0; ceil_buffered = 1'b0;
        wr_ceil(20);
        cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        p0 = upd_seen;
        repeat (42) @(negedge clk);
        chk("R10 immediate ceiling", upd_seen - p0, 2);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_clock();
        t_force_pulse();
        t_x2a();
        t_x2b();
        t_x4();
        t_wrap_up();
        t_wrap_down();
        t_preload();
        t_immediate();
        finish_run();
    end
endmodule